// File: doc/BRIEF.md
# Miss-Dependence Waiting Buffer Bank

This block is one bank of a buffer that parks instructions whose operands wait on outstanding load misses. Entries are claimed at a local tail pointer and released at a local head pointer in program order, so the bank moves in step with the reorder buffer. An instruction that must wait is recorded by setting one bit in a two-dimensional matrix. Each column stands for one outstanding miss and each row for one buffer entry.

Wakeup needs no tag broadcast. The bank ORs together the columns whose misses have completed and masks the result with the occupied rows. It then scans from the head pointer for the oldest set bit. The one-hot result drives the payload read directly, with no index encode and no index decode. A read takes two cycles: on the first edge the entry is chosen, and on the second edge it is read out. The issue side may refuse the entry at the second edge, and in that case nothing is cleared.

A squash moves the tail back and wipes the rows of the removed entries in every column in one cycle. A column that has completed and holds no set bits is handed back as free.

Top module: `wib_bank`

## Requirements
- R1: On `alloc_valid`, when the bank is not full and no squash is present, the payload is stored at the row given by `alloc_idx` (the tail pointer), and the tail advances by one modulo DEPTH. An allocation while the bank is full leaves `alloc_idx` unchanged.
- R2: `full` is high exactly when DEPTH entries are occupied. `retire_valid` releases the head entry. A retire while the bank is empty has no effect.
- R3: `miss_open` turns a free column (number `miss_open_col`) to waiting, and its bit in `col_busy` goes high after the edge. `ins_valid` sets the bit at row `ins_row` in column `ins_miss`.
- R4: Only occupied rows that are set in a completed column are eligible. A row set only in waiting columns is never read out.
- R5: The chosen entry is the first eligible row found when scanning from the head toward the tail, with wrap-around. `rd_onehot` has exactly one bit high, at that row, and `rd_payload` is the row's payload.
- R6: When the bank is idle and `rd_en` is high at an edge, the choice is made at that edge. `rd_valid` is high for one cycle after the next edge. An `rd_en` during that access is ignored.
- R7: A delivered row is cleared in every column, so the next access returns the next-oldest eligible row. The choice also takes in columns that completed during the previous access.
- R8: When `rd_ready` is low at the second edge of an access, `rd_valid` stays low and the row keeps its bit, so a later access offers the same row again.
- R9: `squash_valid` with an occupied `squash_row` removes that row and every younger row. It clears those rows in all columns and sets the tail (and `alloc_idx`) to `squash_row`. Allocate and retire are ignored in that cycle, and an access whose second edge meets the squash delivers nothing.
- R10: A completed column whose bits are all zero is free again after the next edge, and its `col_busy` bit falls.
- R11: After reset the bank is empty, `alloc_idx` is 0, `full` is 0, all columns are free and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Claim the tail entry |
| alloc_payload | input | PW | Payload stored in the claimed entry |
| alloc_idx | output | AW | Current tail row |
| full | output | 1 | All DEPTH entries occupied |
| retire_valid | input | 1 | Release the head entry |
| ins_valid | input | 1 | Record that an entry waits on a miss |
| ins_row | input | AW | Row of the waiting entry |
| ins_miss | input | MW | Column of the miss it waits on |
| miss_open | input | 1 | Mark a free column as waiting |
| miss_open_col | input | MW | Column to open |
| miss_done | input | 1 | Mark a waiting column as completed |
| miss_done_col | input | MW | Column that completed |
| squash_valid | input | 1 | Remove the entries from `squash_row` to the tail |
| squash_row | input | AW | Oldest row removed |
| rd_en | input | 1 | Start a two-cycle access |
| rd_ready | input | 1 | Issue side accepts at the second edge |
| rd_valid | output | 1 | Entry delivered this cycle |
| rd_payload | output | PW | Payload of the delivered entry |
| rd_onehot | output | DEPTH | One-hot row of the delivered entry |
| col_busy | output | NMISS | Column is waiting or completed |

## Verification
The bench builds the bank with DEPTH=8, NMISS=4 and PW=16. With eight rows, a few allocations and retires are enough to reach `full`, make the pointers wrap, and put an older row at a higher index than a younger one, which tests the head-relative scan. With four columns, random traffic opens, completes and frees every column many times. It also hits squashes that land on set rows, refused reads, and completions that arrive in the middle of an access.

// File: rtl/wib_pkg.sv
package wib_pkg;

    typedef enum logic [1:0] {
        COL_FREE = 2'd0,
        COL_WAIT = 2'd1,
        COL_DONE = 2'd2
    } col_state_e;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/wib_ptrs.sv
module wib_ptrs
    import wib_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = idx_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_req,
    input  logic             retire_req,
    input  logic             squash_req,
    input  logic [AW-1:0]    squash_row,
    output logic [AW-1:0]    head,
    output logic [AW-1:0]    tail,
    output logic             full,
    output logic             alloc_fire,
    output logic             retire_fire,
    output logic [DEPTH-1:0] occ,
    output logic [DEPTH-1:0] kill
);
    logic [AW-1:0] head_q, tail_q;
    logic [AW:0]   count_q;
    logic [AW:0]   keep;
    logic [AW-1:0] off;

    assign head        = head_q;
    assign tail        = tail_q;
    assign full        = (count_q == (AW+1)'(DEPTH));
    assign alloc_fire  = alloc_req && !full && !squash_req;
    assign retire_fire = retire_req && (count_q != '0) && !squash_req;
    assign keep        = {1'b0, squash_row - head_q};

    always_comb begin
        occ  = '0;
        kill = '0;
        off  = '0;
        for (int r = 0; r < DEPTH; r++) begin
            off     = AW'(r) - head_q;
            occ[r]  = ({1'b0, off} < count_q);
            kill[r] = squash_req && occ[r] && ({1'b0, off} >= keep);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else if (squash_req) begin
            tail_q  <= squash_row;
            count_q <= keep;
        end else begin
            if (alloc_fire)  tail_q <= tail_q + 1'b1;
            if (retire_fire) head_q <= head_q + 1'b1;
            count_q <= count_q + (AW+1)'(alloc_fire) - (AW+1)'(retire_fire);
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count_q <= (AW+1)'(DEPTH)); // R2
    AST_FULL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (rst)
        full && alloc_req && !squash_req |=> tail_q == $past(tail_q)); // R1
    AST_EMPTY_RETIRE_NOP: assert property (@(posedge clk) disable iff (rst)
        (count_q == '0) && retire_req && !squash_req |=> head_q == $past(head_q)); // R2

endmodule

// File: rtl/wib_colmat.sv
module wib_colmat
    import wib_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NMISS = 8,
    localparam int AW = idx_bits(DEPTH),
    localparam int MW = idx_bits(NMISS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_v,
    input  logic [MW-1:0]    open_col,
    input  logic             done_v,
    input  logic [MW-1:0]    done_col,
    input  logic             ins_v,
    input  logic [AW-1:0]    ins_row,
    input  logic [MW-1:0]    ins_col,
    input  logic [DEPTH-1:0] clr_rows,
    output logic [DEPTH-1:0] ready_vec,
    output logic [NMISS-1:0] col_busy
);
    logic [NMISS-1:0][DEPTH-1:0] done_bits;

    for (genvar c = 0; c < NMISS; c++) begin : g_col
        logic [DEPTH-1:0] bits_q;
        logic [DEPTH-1:0] set_row;
        col_state_e       st_q;

        assign set_row = (ins_v && ins_col == MW'(c))
                       ? ({{(DEPTH-1){1'b0}}, 1'b1} << ins_row) : '0;
        assign done_bits[c] = (st_q == COL_DONE) ? bits_q : '0;
        assign col_busy[c]  = (st_q != COL_FREE);

        always_ff @(posedge clk) begin
            if (rst) begin
                bits_q <= '0;
                st_q   <= COL_FREE;
            end else begin
                bits_q <= (bits_q & ~clr_rows) | set_row;
                case (st_q)
                    COL_FREE: if (open_v && open_col == MW'(c)) st_q <= COL_WAIT;
                    COL_WAIT: if (done_v && done_col == MW'(c)) st_q <= COL_DONE;
                    COL_DONE: if (bits_q == '0) st_q <= COL_FREE;
                    default:  st_q <= COL_FREE;
                endcase
            end
        end

        AST_FREE_COL_EMPTY: assert property (@(posedge clk) disable iff (rst)
            st_q == COL_FREE |-> bits_q == '0); // R10
    end

    always_comb begin
        ready_vec = '0;
        for (int c = 0; c < NMISS; c++) ready_vec |= done_bits[c];
    end

endmodule

// File: rtl/wib_age_pick.sv
module wib_age_pick
    import wib_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = idx_bits(DEPTH)
) (
    input  logic [DEPTH-1:0] elig,
    input  logic [AW-1:0]    head,
    output logic [DEPTH-1:0] pick
);
    logic          found;
    logic [AW-1:0] idx;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + AW'(k);
            if (!found && elig[idx]) begin
                pick[idx] = 1'b1;
                found     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wib_bank.sv
module wib_bank
    import wib_pkg::*;
#(
    parameter int PW    = 32,
    parameter int DEPTH = 16,
    parameter int NMISS = 8,
    localparam int AW = idx_bits(DEPTH),
    localparam int MW = idx_bits(NMISS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_valid,
    input  logic [PW-1:0]    alloc_payload,
    output logic [AW-1:0]    alloc_idx,
    output logic             full,
    input  logic             retire_valid,
    input  logic             ins_valid,
    input  logic [AW-1:0]    ins_row,
    input  logic [MW-1:0]    ins_miss,
    input  logic             miss_open,
    input  logic [MW-1:0]    miss_open_col,
    input  logic             miss_done,
    input  logic [MW-1:0]    miss_done_col,
    input  logic             squash_valid,
    input  logic [AW-1:0]    squash_row,
    input  logic             rd_en,
    input  logic             rd_ready,
    output logic             rd_valid,
    output logic [PW-1:0]    rd_payload,
    output logic [DEPTH-1:0] rd_onehot,
    output logic [NMISS-1:0] col_busy
);
    logic [AW-1:0]    head, tail;
    logic             alloc_fire, retire_fire;
    logic [DEPTH-1:0] occ, kill, ready_vec, elig, pick, grant, clr_rows;
    logic [DEPTH-1:0] sel_q;
    logic             busy_q;
    logic [PW-1:0]    payload_q [DEPTH];
    logic [PW-1:0]    rd_data;
    logic             rd_valid_q;
    logic [PW-1:0]    rd_payload_q;
    logic [DEPTH-1:0] rd_onehot_q;

    wib_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst(rst),
        .alloc_req(alloc_valid), .retire_req(retire_valid),
        .squash_req(squash_valid), .squash_row(squash_row),
        .head(head), .tail(tail), .full(full),
        .alloc_fire(alloc_fire), .retire_fire(retire_fire),
        .occ(occ), .kill(kill)
    );

    wib_colmat #(.DEPTH(DEPTH), .NMISS(NMISS)) u_mat (
        .clk(clk), .rst(rst),
        .open_v(miss_open), .open_col(miss_open_col),
        .done_v(miss_done), .done_col(miss_done_col),
        .ins_v(ins_valid), .ins_row(ins_row), .ins_col(ins_miss),
        .clr_rows(clr_rows), .ready_vec(ready_vec), .col_busy(col_busy)
    );

    assign elig = ready_vec & occ;

    wib_age_pick #(.DEPTH(DEPTH)) u_pick (
        .elig(elig), .head(head), .pick(pick)
    );

    assign grant = sel_q & occ & {DEPTH{busy_q && rd_ready && !squash_valid}};

    assign clr_rows = (alloc_fire  ? ({{(DEPTH-1){1'b0}}, 1'b1} << tail) : '0)
                    | (retire_fire ? ({{(DEPTH-1){1'b0}}, 1'b1} << head) : '0)
                    | kill | grant;

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < DEPTH; r++) rd_data |= payload_q[r] & {PW{grant[r]}};
    end

    always_ff @(posedge clk) begin
        if (alloc_fire) payload_q[tail] <= alloc_payload;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q       <= 1'b0;
            sel_q        <= '0;
            rd_valid_q   <= 1'b0;
            rd_payload_q <= '0;
            rd_onehot_q  <= '0;
        end else begin
            if (!busy_q && rd_en) begin
                sel_q  <= pick;
                busy_q <= 1'b1;
            end else begin
                busy_q <= 1'b0;
            end
            rd_valid_q   <= |grant;
            rd_payload_q <= rd_data;
            rd_onehot_q  <= grant;
        end
    end

    assign alloc_idx  = tail;
    assign rd_valid   = rd_valid_q;
    assign rd_payload = rd_payload_q;
    assign rd_onehot  = rd_onehot_q;

    AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $countones(rd_onehot) == 1); // R5
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en, 2)); // R6
    AST_ROW_WAS_READY: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(ready_vec) & rd_onehot) != '0); // R4
    AST_REFUSE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_ready)); // R8
    AST_SQUASH_DROPS_READ: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !$past(squash_valid)); // R9

endmodule

// File: tb/sim_wib_bank.sv
`timescale 1ns/1ps
module sim_wib_bank;
    localparam int PW = 16;
    localparam int D  = 8;
    localparam int NM = 4;
    localparam int AW = 3;
    localparam int MW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alloc_valid = 0, retire_valid = 0, ins_valid = 0, miss_open = 0, miss_done = 0;
    logic squash_valid = 0, rd_en = 0, rd_ready = 0;
    logic [PW-1:0] alloc_payload = '0;
    logic [AW-1:0] ins_row = '0, squash_row = '0;
    logic [MW-1:0] ins_miss = '0, miss_open_col = '0, miss_done_col = '0;
    logic [AW-1:0] alloc_idx;
    logic full, rd_valid;
    logic [PW-1:0] rd_payload;
    logic [D-1:0] rd_onehot;
    logic [NM-1:0] col_busy;

    always #2 clk = ~clk;

    wib_bank #(.PW(PW), .DEPTH(D), .NMISS(NM)) u0 (
        .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_payload(alloc_payload),
        .alloc_idx(alloc_idx), .full(full), .retire_valid(retire_valid),
        .ins_valid(ins_valid), .ins_row(ins_row), .ins_miss(ins_miss),
        .miss_open(miss_open), .miss_open_col(miss_open_col),
        .miss_done(miss_done), .miss_done_col(miss_done_col),
        .squash_valid(squash_valid), .squash_row(squash_row),
        .rd_en(rd_en), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_payload(rd_payload), .rd_onehot(rd_onehot), .col_busy(col_busy)
    );

    int nvec = 0, nfail = 0;
    bit finished = 0;

    // behavioural reference state
    int m_head, m_tail, m_cnt, m_sel;
    bit m_busy;
    bit m_bits [NM][D];
    int m_st [NM];             // 0 free, 1 waiting, 2 completed
    logic [PW-1:0] m_pay [D];
    bit e_valid;
    logic [PW-1:0] e_pay;
    logic [D-1:0] e_oh;

    function automatic bit m_occ(int r);
        return ((r - m_head + D) % D) < m_cnt;
    endfunction

    function automatic bit row_set(int r);
        for (int c = 0; c < NM; c++) if (m_bits[c][r]) return 1;
        return 0;
    endfunction

    task automatic model_step();
        bit rdy [D];
        bit clr [D];
        bit zero [NM];
        int pick, keep;
        bit grant, afire, rfire;
        if (rst) begin
            m_head = 0; m_tail = 0; m_cnt = 0; m_busy = 0; m_sel = -1;
            for (int c = 0; c < NM; c++) begin
                m_st[c] = 0;
                for (int r = 0; r < D; r++) m_bits[c][r] = 0;
            end
            e_valid = 0; e_pay = '0; e_oh = '0;
            return;
        end
        for (int r = 0; r < D; r++) begin
            rdy[r] = 0;
            for (int c = 0; c < NM; c++) if (m_st[c] == 2 && m_bits[c][r]) rdy[r] = m_occ(r);
        end
        pick = -1;
        for (int k = 0; k < m_cnt; k++)
            if (pick < 0 && rdy[(m_head + k) % D]) pick = (m_head + k) % D;
        grant = m_busy && rd_ready && !squash_valid && m_sel >= 0 && m_occ(m_sel);
        afire = alloc_valid && m_cnt < D && !squash_valid;
        rfire = retire_valid && m_cnt > 0 && !squash_valid;
        e_valid = grant;
        e_oh    = grant ? (D'(1) << m_sel) : '0;
        e_pay   = grant ? m_pay[m_sel] : '0;
        keep = (int'(squash_row) - m_head + D) % D;
        for (int r = 0; r < D; r++)
            clr[r] = (afire && r == m_tail) || (rfire && r == m_head) || (grant && r == m_sel)
                   || (squash_valid && m_occ(r) && ((r - m_head + D) % D) >= keep);
        for (int c = 0; c < NM; c++) begin
            zero[c] = 1;
            for (int r = 0; r < D; r++) if (m_bits[c][r]) zero[c] = 0;
        end
        for (int c = 0; c < NM; c++) begin
            for (int r = 0; r < D; r++)
                m_bits[c][r] = (m_bits[c][r] && !clr[r])
                             || (ins_valid && int'(ins_miss) == c && int'(ins_row) == r);
            if (m_st[c] == 0 && miss_open && int'(miss_open_col) == c) m_st[c] = 1;
            else if (m_st[c] == 1 && miss_done && int'(miss_done_col) == c) m_st[c] = 2;
            else if (m_st[c] == 2 && zero[c]) m_st[c] = 0;
        end
        if (afire) m_pay[m_tail] = alloc_payload;
        if (squash_valid) begin
            m_tail = int'(squash_row); m_cnt = keep;
        end else begin
            if (afire) m_tail = (m_tail + 1) % D;
            if (rfire) m_head = (m_head + 1) % D;
            m_cnt = m_cnt + int'(afire) - int'(rfire);
        end
        if (!m_busy && rd_en) begin m_sel = pick; m_busy = 1; end
        else m_busy = 0;
    endtask

    task automatic chk(string tag, longint act, longint exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        logic [NM-1:0] eb;
        for (int c = 0; c < NM; c++) eb[c] = (m_st[c] != 0);
        chk("R1 alloc_idx", alloc_idx, m_tail);
        chk("R2 full", full, (m_cnt == D));
        chk("R10 col_busy", col_busy, eb);
        chk("R6 rd_valid", rd_valid, e_valid);
        if (e_valid) begin
            chk("R5 rd_onehot", rd_onehot, e_oh);
            chk("R7 rd_payload", rd_payload, e_pay);
        end
    endtask

    task automatic clear_in();
        alloc_valid = 0; retire_valid = 0; ins_valid = 0; miss_open = 0; miss_done = 0;
        squash_valid = 0; rd_en = 0; rd_ready = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        clear_in();
    endtask

    logic cap_v;
    logic [PW-1:0] cap_p;
    logic [D-1:0] cap_oh;

    task automatic rd(bit ready);
        rd_en = 1; tick();
        rd_ready = ready; tick();
        cap_v = rd_valid; cap_p = rd_payload; cap_oh = rd_onehot;
    endtask

    task automatic alloc(logic [PW-1:0] p);
        alloc_valid = 1; alloc_payload = p; tick();
    endtask

    task automatic open(int c);
        miss_open = 1; miss_open_col = MW'(c); tick();
    endtask

    task automatic done(int c);
        miss_done = 1; miss_done_col = MW'(c); tick();
    endtask

    task automatic ins(int r, int c);
        ins_valid = 1; ins_row = AW'(r); ins_miss = MW'(c); tick();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        clear_in();
        rst = 1; tick(); tick();
        rst = 0;
        // R11 reset state
        chk("R11 alloc_idx", alloc_idx, 0);
        chk("R11 full", full, 0);
        chk("R11 col_busy", col_busy, 0);
        chk("R11 rd_valid", rd_valid, 0);

        for (int i = 0; i < 6; i++) alloc(16'hA0 + PW'(i));   // R1 rows 0..5
        chk("R1 tail after six", alloc_idx, 6);
        open(1); open(2);
        ins(1, 1); ins(3, 1); ins(4, 1); ins(2, 2);
        chk("R3 col_busy", col_busy, 4'b0110);

        rd(1);
        chk("R4 waiting column not eligible", cap_v, 0);

        done(1);
        rd(1);
        chk("R5 oldest payload", cap_p, 16'hA1);
        chk("R5 oldest onehot", cap_oh, 8'b0000_0010);
        rd(1);
        chk("R7 next oldest", cap_p, 16'hA3);
        rd(0);
        chk("R8 refused no output", cap_v, 0);
        rd(1);
        chk("R8 same row offered again", cap_p, 16'hA4);
        tick();
        chk("R10 emptied column freed", col_busy, 4'b0100);

        done(2);
        rd(1);
        chk("R7 second column", cap_oh, 8'b0000_0100);
        tick();
        chk("R10 all free", col_busy, 0);

        // R9 squash rows 4,5 that wait on column 0
        open(0); ins(4, 0); ins(5, 0);
        squash_valid = 1; squash_row = 3'd4; tick();
        chk("R9 tail moved back", alloc_idx, 4);
        done(0);
        rd(1);
        chk("R9 squashed rows cleared", cap_v, 0);
        tick();
        chk("R9 column freed after squash", col_busy, 0);

        // R2 fill with wrap
        retire_valid = 1; tick(); retire_valid = 1; tick();
        for (int i = 0; i < 6; i++) alloc(16'hB0 + PW'(i));   // rows 4,5,6,7,0,1
        chk("R2 full", full, 1);
        chk("R1 tail wrapped", alloc_idx, 2);
        alloc(16'hEE);
        chk("R1 alloc while full ignored", alloc_idx, 2);

        // R5 age across wrap: row 6 older than row 1
        open(3); ins(1, 3); ins(6, 3); done(3);
        rd(1);
        chk("R5 wrap order first", cap_p, 16'hB2);
        rd(1);
        chk("R5 wrap order second", cap_p, 16'hB5);
        tick();

        // random traffic checked against the model every cycle
        for (int cyc = 0; cyc < 3000; cyc++) begin
            int oc, dc, r, c;
            if ($urandom % 3 == 0) begin alloc_valid = 1; alloc_payload = PW'($urandom); end
            if (m_cnt > 0 && !row_set(m_head) && $urandom % 4 == 0) retire_valid = 1;
            oc = $urandom % NM;
            if (m_st[oc] == 0 && $urandom % 4 == 0) begin miss_open = 1; miss_open_col = MW'(oc); end
            dc = $urandom % NM;
            if (m_st[dc] == 1 && $urandom % 6 == 0) begin miss_done = 1; miss_done_col = MW'(dc); end
            if (m_cnt > 0 && $urandom % 40 == 0) begin
                squash_valid = 1; squash_row = AW'((m_head + int'($urandom % m_cnt)) % D);
            end else if (m_cnt > 0 && $urandom % 2 == 0) begin
                r = (m_head + int'($urandom % m_cnt)) % D;
                c = $urandom % NM;
                if (m_st[c] == 1 && !row_set(r) && !(retire_valid && r == m_head)) begin
                    ins_valid = 1; ins_row = AW'(r); ins_miss = MW'(c);
                end
            end
            rd_en = ($urandom % 3 == 0);
            rd_ready = ($urandom % 4 != 0);
            tick();
        end

        finished = 1;
        summary();
    end
endmodule